// File: doc/BRIEF.md
# Jitter Attenuator Elastic Store

This block is a one-bit-wide elastic store that sits in a line data path and smooths timing jitter. Bits are written on a single-cycle write enable that may come in any gapped or bursty pattern. Bits are read out on a strobe made by dividing a fast reference clock, which runs at sixteen times the line rate. The reference clock is the only clock, and the write enable is synchronous to it. The nominal divide ratio is 16.

The read rate is steered by the fill level. The divider is normally 16. When the fill strays too far above the centre, one period is shortened to 15 reference cycles. When the fill strays too far below the centre, one period is stretched to 17. Each stretched or shortened period raises a sticky limit-trip flag, and software clears the flag with a pulse. The capacity is selectable as 32 or 128 bits.

A bypass input removes the store from the path. Reset or any change of the capacity select re-centres the store at half depth.

Top module: `jitter_elastic_store`

## Requirements
- R1: With `deepSel`=1 the store holds at most 128 bits, and with `deepSel`=0 at most 32 bits. A write offered while the store is full and no read happens in that cycle is dropped.
- R2: After reset, and on the clock edge where `deepSel` differs from its value at the previous edge, the store is refilled with depth/2 zero bits. In that same re-centre, the divider restarts at ratio 16, `rdBit` goes to 0 and the internal strobe goes to 0. A write offered on that edge is ignored.
- R3: While the fill stays within the limit window, the internal read strobe pulses for one cycle once every 16 clocks. The first pulse follows the 16th edge after reset release or a re-centre.
- R4: At the end of each read period the next ratio is chosen from the fill. If the fill is above depth/2+L, the ratio is 15. If the fill is below depth/2−L, the ratio is 17. Otherwise the ratio is 16. L is 14 for the 32-bit depth and 60 for the 128-bit depth, which is half of the peak-to-peak limit of 28 or 120.
- R5: `limitTrip` is set by every period choice of 15 or 17 and stays set until it is cleared.
- R6: A `tripClr` pulse clears `limitTrip`. If a new 15 or 17 choice happens in the same cycle as the clear, the flag stays set.
- R7: Bits leave in the order they were written, one bit per read strobe, for any gapped or bursty write pattern.
- R8: On a read strobe with an empty store, the strobe still pulses and `rdBit` keeps its previous value.
- R9: With `bypass`=1, `rdBit` equals `wrBit` and `rdEn` equals `wrEn` in the same cycle. The store and the divider keep running underneath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, sixteen times the line rate |
| rstN | input | 1 | Synchronous active-low reset |
| wrBit | input | 1 | Incoming data bit |
| wrEn | input | 1 | Single-cycle write enable, may be gapped or bursty |
| deepSel | input | 1 | Capacity select: 1 = 128 bits, 0 = 32 bits |
| bypass | input | 1 | 1 = store removed from the path |
| tripClr | input | 1 | Pulse that clears the limit-trip flag |
| rdBit | output | 1 | Outgoing data bit |
| rdEn | output | 1 | Outgoing bit strobe |
| limitTrip | output | 1 | Sticky flag, set when a period of 15 or 17 is used |

## Verification
The store is driven with several write patterns:
- A write once every 16 clocks matches the nominal read rate. It shows that the fill holds still and the ratio stays at 16.
- A solid burst of writes pushes the fill past the upper limit. It separates the 15-ratio branch and the flag setting from nominal running.
- A long silence drains the fill below the lower limit and then to empty. It separates the 17 ratio from the underrun hold.

Other patterns check the remaining behaviour:
- Continuous writing fills the store to capacity and shows that overflowing writes are dropped.
- Sparse random writes in the deep mode show order preservation at the other capacity.
- Toggling the capacity select and asserting bypass exercise the re-centre and the pass-through.

// File: rtl/jes_pkg.sv
package jes_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic recentre;  // refill at half depth this edge
    logic tick;      // end of a read period
    logic deepMode;  // current capacity select
  } jesCtrlT;
endpackage

// File: rtl/jes_datapath.sv
module jes_datapath
  import jes_pkg::*;
#(
  parameter int DEEP_BITS    = 128,
  parameter int SHALLOW_BITS = 32,
  localparam int PW = $clog2(DEEP_BITS),
  localparam int FW = PW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  jesCtrlT       ctl,
  input  logic          wrBit,
  input  logic          wrEn,
  output logic [FW-1:0] fill,
  output logic          rdBitQ
);
  logic [DEEP_BITS-1:0] mem;
  logic [PW-1:0] wrPtr, rdPtr, mask;
  logic [FW-1:0] depth, half;
  logic doRead, doWrite;

  always_comb begin
    depth   = ctl.deepMode ? FW'(DEEP_BITS) : FW'(SHALLOW_BITS);
    half    = depth >> 1;
    mask    = PW'(depth - 1'b1);
    doRead  = ctl.tick && (fill != '0);
    doWrite = wrEn && ((fill != depth) || doRead);
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.recentre) begin
      mem    <= '0;
      rdPtr  <= '0;
      wrPtr  <= PW'(half);
      fill   <= half;
      rdBitQ <= 1'b0;
    end else begin
      if (doWrite) begin
        mem[wrPtr] <= wrBit;
        wrPtr      <= (wrPtr + 1'b1) & mask;
      end
      if (doRead) begin
        rdBitQ <= mem[rdPtr];
        rdPtr  <= (rdPtr + 1'b1) & mask;
      end
      fill <= fill + FW'(doWrite) - FW'(doRead);
    end
  end

  assert_fill_cap_R1: assert property (@(posedge clk)
    disable iff (!rstN || ctl.recentre) fill <= depth);

  assert_recentre_R2: assert property (@(posedge clk)
    disable iff (!rstN) ctl.recentre |=> (fill == $past(half)) && !rdBitQ);

  assert_underrun_hold_R8: assert property (@(posedge clk)
    disable iff (!rstN) (ctl.tick && fill == '0) |=> $stable(rdBitQ));
endmodule

// File: rtl/jes_control.sv
module jes_control
  import jes_pkg::*;
#(
  parameter int DEEP_BITS    = 128,
  parameter int SHALLOW_BITS = 32,
  parameter int PP_DEEP      = 120,
  parameter int PP_SHALLOW   = 28,
  parameter int NOM_DIV      = 16,
  localparam int FW = $clog2(DEEP_BITS) + 1,
  localparam int CW = $clog2(NOM_DIV + 2),
  localparam int DEEP_HI = DEEP_BITS / 2 + PP_DEEP / 2,
  localparam int DEEP_LO = DEEP_BITS / 2 - PP_DEEP / 2,
  localparam int SH_HI   = SHALLOW_BITS / 2 + PP_SHALLOW / 2,
  localparam int SH_LO   = SHALLOW_BITS / 2 - PP_SHALLOW / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          deepSel,
  input  logic [FW-1:0] fill,
  input  logic          tripClr,
  output jesCtrlT       ctl,
  output logic          rdEnQ,
  output logic          tripQ
);
  logic deepSelQ;
  logic [CW-1:0] divCnt, ratio, nextRatio;
  logic [FW-1:0] hiLim, loLim;
  logic tick, recentre;

  always_comb begin
    recentre  = deepSel != deepSelQ;
    tick      = (divCnt == ratio - 1'b1) && !recentre;
    hiLim     = deepSel ? FW'(DEEP_HI) : FW'(SH_HI);
    loLim     = deepSel ? FW'(DEEP_LO) : FW'(SH_LO);
    if (fill > hiLim)      nextRatio = CW'(NOM_DIV - 1);
    else if (fill < loLim) nextRatio = CW'(NOM_DIV + 1);
    else                   nextRatio = CW'(NOM_DIV);
    ctl.recentre = recentre;
    ctl.tick     = tick;
    ctl.deepMode = deepSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deepSelQ <= deepSel;
      divCnt   <= '0;
      ratio    <= CW'(NOM_DIV);
      rdEnQ    <= 1'b0;
      tripQ    <= 1'b0;
    end else begin
      deepSelQ <= deepSel;
      rdEnQ    <= tick;
      if (recentre) begin
        divCnt <= '0;
        ratio  <= CW'(NOM_DIV);
      end else if (tick) begin
        divCnt <= '0;
        ratio  <= nextRatio;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (tick && nextRatio != CW'(NOM_DIV)) tripQ <= 1'b1;
      else if (tripClr)                      tripQ <= 1'b0;
    end
  end

  assert_trip_high_R5: assert property (@(posedge clk)
    disable iff (!rstN) (tick && fill > hiLim) |=> tripQ);

  assert_trip_low_R4: assert property (@(posedge clk)
    disable iff (!rstN) (tick && fill < loLim) |=> tripQ);

  assert_clear_R6: assert property (@(posedge clk)
    disable iff (!rstN) (tripClr && !tick) |=> !tripQ);

  assert_strobe_gap_R3: assert property (@(posedge clk)
    disable iff (!rstN) rdEnQ |=> !rdEnQ);
endmodule

// File: rtl/jitter_elastic_store.sv
module jitter_elastic_store
  import jes_pkg::*;
#(
  parameter int DEEP_BITS    = 128,
  parameter int SHALLOW_BITS = 32,
  parameter int PP_DEEP      = 120,
  parameter int PP_SHALLOW   = 28,
  parameter int NOM_DIV      = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrBit,
  input  logic wrEn,
  input  logic deepSel,
  input  logic bypass,
  input  logic tripClr,
  output logic rdBit,
  output logic rdEn,
  output logic limitTrip
);
  localparam int FW = $clog2(DEEP_BITS) + 1;

  jesCtrlT ctl;
  logic [FW-1:0] fill;
  logic rdBitQ, rdEnQ;

  jes_control #(
    .DEEP_BITS(DEEP_BITS), .SHALLOW_BITS(SHALLOW_BITS),
    .PP_DEEP(PP_DEEP), .PP_SHALLOW(PP_SHALLOW), .NOM_DIV(NOM_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .deepSel(deepSel), .fill(fill),
    .tripClr(tripClr), .ctl(ctl), .rdEnQ(rdEnQ), .tripQ(limitTrip)
  );

  jes_datapath #(
    .DEEP_BITS(DEEP_BITS), .SHALLOW_BITS(SHALLOW_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrBit(wrBit), .wrEn(wrEn),
    .fill(fill), .rdBitQ(rdBitQ)
  );

  assign rdBit = bypass ? wrBit : rdBitQ;
  assign rdEn  = bypass ? wrEn  : rdEnQ;

  assert_bypass_R9: assert property (@(posedge clk)
    disable iff (!rstN) bypass |-> (rdEn == wrEn) && (rdBit == wrBit));
endmodule

// File: tb/jitter_elastic_store_bench.sv
module jitter_elastic_store_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrBit = 1'b0, wrEn = 1'b0, deepSel = 1'b0, bypass = 1'b0, tripClr = 1'b0;
  logic rdBit, rdEn, limitTrip;

  int checks = 0, failures = 0;
  string curReq = "R2";
  bit done = 0;

  // behavioural reference model
  bit mq[$];
  int mCnt = 0, mRatio = 16;
  bit mBit = 0, mEn = 0, mTrip = 0, mPrevDeep = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jitter_elastic_store u_jitter_elastic_store (
    .clk(clk), .rstN(rstN), .wrBit(wrBit), .wrEn(wrEn), .deepSel(deepSel),
    .bypass(bypass), .tripClr(tripClr), .rdBit(rdBit), .rdEn(rdEn),
    .limitTrip(limitTrip)
  );

  task automatic refill(input bit deep);
    mq.delete();
    for (int i = 0; i < (deep ? 64 : 16); i++) mq.push_back(1'b0);
    mCnt = 0; mRatio = 16; mBit = 0; mEn = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      refill(deepSel); mTrip = 0; mPrevDeep = deepSel;
    end else if (deepSel != mPrevDeep) begin
      refill(deepSel); if (tripClr) mTrip = 0; mPrevDeep = deepSel;
    end else begin
      automatic int d = deepSel ? 128 : 32;
      automatic int lim = deepSel ? 60 : 14;
      automatic int f = mq.size();
      automatic bit tick = (mCnt == mRatio - 1);
      automatic int nr = (f > d/2 + lim) ? 15 : (f < d/2 - lim) ? 17 : 16;
      automatic bit rd = tick && f > 0;
      automatic bit wr = wrEn && (f < d || rd);
      if (rd) mBit = mq.pop_front();
      if (wr) mq.push_back(wrBit);
      mEn = tick;
      if (tick) begin mCnt = 0; mRatio = nr; end else mCnt++;
      if (tick && nr != 16) mTrip = 1; else if (tripClr) mTrip = 0;
    end
  end

  task automatic check(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %b expected %b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    check("rdBit", rdBit, bypass ? wrBit : mBit);
    check("rdEn", rdEn, bypass ? wrEn : mEn);
    check("limitTrip", limitTrip, mTrip);
  end

  // one cycle of stimulus; inputs change after the negedge compare
  task automatic step(input bit we);
    @(negedge clk); #1;
    wrEn = we; wrBit = we ? 1'($urandom) : 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    curReq = "R2";
    @(negedge clk); #1;
    check("reset rdBit", rdBit, 1'b0);
    check("reset limitTrip", limitTrip, 1'b0);
    curReq = "R3";   // write rate matches read rate
    for (int i = 0; i < 320; i++) step(i % 16 == 3);
    curReq = "R4";   // burst pushes fill over the upper limit
    for (int i = 0; i < 24; i++) step(1'b1);
    curReq = "R5";
    for (int i = 0; i < 300; i++) step(i % 16 == 0);
    curReq = "R6";   // clear pulse, then clear held while events fire
    @(negedge clk); #1 tripClr = 1'b1; @(negedge clk); #1 tripClr = 1'b0;
    for (int i = 0; i < 30; i++) step(1'b1);
    tripClr = 1'b1;
    for (int i = 0; i < 80; i++) step(1'b0);
    tripClr = 1'b0;
    curReq = "R8";   // starve: ratio 17, then empty reads
    for (int i = 0; i < 900; i++) step(1'b0);
    curReq = "R1";   // overfill: writes dropped at capacity
    for (int i = 0; i < 200; i++) step(1'b1);
    for (int i = 0; i < 200; i++) step(1'b0);
    curReq = "R2";   // switch to deep
    @(negedge clk); #1 deepSel = 1'b1;
    curReq = "R7";   // sparse random writes, deep mode
    for (int i = 0; i < 1500; i++) step(($urandom % 15) == 0);
    curReq = "R1";
    for (int i = 0; i < 400; i++) step(1'b1);
    curReq = "R9";
    bypass = 1'b1;
    for (int i = 0; i < 60; i++) step(($urandom % 3) == 0);
    bypass = 1'b0;
    curReq = "R2";   // back to shallow
    @(negedge clk); #1 deepSel = 1'b0;
    curReq = "R7";
    for (int i = 0; i < 600; i++) step(($urandom % 17) < 2);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    done = 1;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule